// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block decides which of five interrupt sources a small 8-bit processor takes next. The sources are a non-maskable trap, three vectored restart lines (levels 7.5, 6.5 and 5.5) and one general request. The processor raises a sample strobe in the next-to-last clock of every instruction. Only at that strobe does the controller look at its inputs. It then applies the software interrupt-enable flag and the per-line restart masks, and it picks the single highest-priority source that is eligible.

The result is registered and appears for exactly one clock after the strobe. It carries an accept pulse, a source code and a 16-bit restart address. For the general request it also carries an acknowledge request. That request tells the processor to hold its program counter and run an acknowledge cycle with read-strobe timing, in which an external device supplies the opcode. The controller owns the enable flag and the mask bits. Software sets and clears the flag through two control inputs, and the controller clears the flag itself whenever it accepts a maskable source.

Top module: `rst_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the enable flag and all three mask bits, and it leaves accept, gen_ack, src_code (0) and vector (0) inactive.
- R2: The inputs are evaluated only in a cycle where sample_stb is high. accept pulses in the single cycle after such a strobe and stays low at every other time, whatever the input levels are.
- R3: Priority from highest to lowest is trap, restart 7.5, restart 6.5, restart 5.5, then the general request. Only the highest eligible source is accepted.
- R4: The trap is accepted whenever it is high at a strobe, regardless of the enable flag and the masks.
- R5: mask_data bit 2 masks restart 7.5, bit 1 masks restart 6.5 and bit 0 masks restart 5.5, with 1 meaning masked. The value is loaded when mask_wr is high, is shown on mask_q, and stops that line from being accepted.
- R6: Restarts and the general request are accepted only while the enable flag is 1. ien_set sets the flag and ien_clr clears it, and ien_clr wins when both are high.
- R7: Accepting any maskable source clears the enable flag on the same edge that raises accept. This acceptance wins over an ien_set in the strobe cycle.
- R8: src_code is 1 for trap, 2 for 7.5, 3 for 6.5, 4 for 5.5, 5 for the general request and 0 for none. vector is 0x0024, 0x003C, 0x0034 or 0x002C for the trap and the three restart levels, and 0 otherwise.
- R9: An accepted general request raises gen_ack together with accept, which asks for the external acknowledge cycle and holds the program counter. gen_ack is never high for any other source.
- R10: A source that loses arbitration is not stored. It is accepted at a later strobe only if its input is still high and it is eligible then.
- R11: Accepting the trap leaves the enable flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable trap line |
| rst75_in | input | 1 | Restart level 7.5 line |
| rst65_in | input | 1 | Restart level 6.5 line |
| rst55_in | input | 1 | Restart level 5.5 line |
| gen_req_in | input | 1 | General interrupt request |
| sample_stb | input | 1 | Next-to-last instruction clock strobe |
| ien_set | input | 1 | Set the enable flag |
| ien_clr | input | 1 | Clear the enable flag |
| mask_wr | input | 1 | Load the restart masks |
| mask_data | input | 3 | New mask bits (2: 7.5, 1: 6.5, 0: 5.5) |
| accept | output | 1 | Interrupt accepted (one-cycle pulse) |
| src_code | output | 3 | Accepted source code |
| vector | output | 16 | Restart address |
| gen_ack | output | 1 | Acknowledge cycle request, PC hold |
| ien | output | 1 | Current enable flag |
| mask_q | output | 3 | Current restart masks |

## Verification
Four properties are checked on every cycle. Accept may only follow a strobe. A trap seen at a strobe must win. A maskable acceptance must leave the enable flag cleared. gen_ack must always come with accept and the general request code, and never with a vector. Several properties need planned stimulus and can only be shown by the bench's scenarios: the full priority order under different mixes of inputs, the effect of each mask bit, a losing line being taken at a later strobe, and the order between software enables and automatic clearing.

// File: rtl/rst_irq_pkg.sv
package rst_irq_pkg;

    localparam int NUM_SRC = 5;
    localparam int NUM_RST = 3;
    localparam int VEC_W   = 16;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_GEN  = 3'd5
    } irq_src_e;

    typedef struct packed {
        logic             accept;
        irq_src_e         src;
        logic [VEC_W-1:0] vector;
        logic             gen_ack;
    } grant_t;

    // priority slot 0 is the highest
    function automatic irq_src_e slot_to_src(int slot);
        case (slot)
            0:       return SRC_TRAP;
            1:       return SRC_R75;
            2:       return SRC_R65;
            3:       return SRC_R55;
            4:       return SRC_GEN;
            default: return SRC_NONE;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] restart_addr(irq_src_e s);
        case (s)
            SRC_TRAP: return VEC_W'(16'h0024);
            SRC_R75:  return VEC_W'(16'h003C);
            SRC_R65:  return VEC_W'(16'h0034);
            SRC_R55:  return VEC_W'(16'h002C);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/rst_irq_state.sv
module rst_irq_state
    import rst_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ien_set,
    input  logic               ien_clr,
    input  logic               mask_wr,
    input  logic [NUM_RST-1:0] mask_data,
    input  logic               take_maskable,
    output logic               ien_q,
    output logic [NUM_RST-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            if (mask_wr)
                mask_q <= mask_data;
            if (take_maskable || ien_clr)
                ien_q <= 1'b0;
            else if (ien_set)
                ien_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rst_irq_arb.sv
module rst_irq_arb
    import rst_irq_pkg::*;
(
    input  logic               trap_line,
    input  logic [NUM_RST-1:0] rst_lines,   // index NUM_RST-1 is the highest level
    input  logic               gen_line,
    input  logic               ien,
    input  logic [NUM_RST-1:0] mask,
    output grant_t             grant_d
);

    logic [NUM_SRC-1:0] elig;

    assign elig[0]         = trap_line;
    assign elig[NUM_SRC-1] = gen_line & ien;

    for (genvar k = 0; k < NUM_RST; k++) begin : g_rst_slot
        localparam int LINE = NUM_RST - 1 - k;
        assign elig[1 + k] = rst_lines[LINE] & ien & ~mask[LINE];
    end

    irq_src_e win;

    always_comb begin
        win = SRC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i])
                win = slot_to_src(i);
        end
        grant_d.accept  = (win != SRC_NONE);
        grant_d.src     = win;
        grant_d.vector  = restart_addr(win);
        grant_d.gen_ack = (win == SRC_GEN);
    end

endmodule

// File: rtl/rst_irq_ctrl.sv
module rst_irq_ctrl
    import rst_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               trap_in,
    input  logic               rst75_in,
    input  logic               rst65_in,
    input  logic               rst55_in,
    input  logic               gen_req_in,
    input  logic               sample_stb,
    input  logic               ien_set,
    input  logic               ien_clr,
    input  logic               mask_wr,
    input  logic [2:0]         mask_data,
    output logic               accept,
    output logic [2:0]         src_code,
    output logic [15:0]        vector,
    output logic               gen_ack,
    output logic               ien,
    output logic [2:0]         mask_q
);

    grant_t grant_d;
    grant_t grant_q;
    logic   take;
    logic   take_maskable;

    rst_irq_arb u_arb (
        .trap_line (trap_in),
        .rst_lines ({rst75_in, rst65_in, rst55_in}),
        .gen_line  (gen_req_in),
        .ien       (ien),
        .mask      (mask_q),
        .grant_d   (grant_d)
    );

    assign take          = sample_stb & grant_d.accept;
    assign take_maskable = take & (grant_d.src != SRC_TRAP);

    rst_irq_state u_state (
        .clk           (clk),
        .rst           (rst),
        .ien_set       (ien_set),
        .ien_clr       (ien_clr),
        .mask_wr       (mask_wr),
        .mask_data     (mask_data),
        .take_maskable (take_maskable),
        .ien_q         (ien),
        .mask_q        (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst || !take)
            grant_q <= '{accept: 1'b0, src: SRC_NONE, vector: '0, gen_ack: 1'b0};
        else
            grant_q <= grant_d;
    end

    assign accept   = grant_q.accept;
    assign src_code = grant_q.src;
    assign vector   = grant_q.vector;
    assign gen_ack  = grant_q.gen_ack;

    // R2: accept only one cycle after a strobe
    a_r2_accept_after_stb: assert property (@(posedge clk) disable iff (rst)
        accept |-> ($past(sample_stb) && !$past(rst)));

    // R4: a trap seen at a strobe always wins
    a_r4_trap_wins: assert property (@(posedge clk) disable iff (rst)
        ($past(sample_stb && trap_in) && !$past(rst)) |-> (accept && src_code == 3'd1));

    // R7: maskable acceptance leaves the enable flag cleared
    a_r7_ien_cleared: assert property (@(posedge clk) disable iff (rst)
        (accept && src_code != 3'd1) |-> !ien);

    // R9: acknowledge request only for an accepted general request, no vector
    a_r9_gen_ack_only: assert property (@(posedge clk) disable iff (rst)
        gen_ack |-> (accept && src_code == 3'd5 && vector == 16'h0));

endmodule

// File: tb/rst_irq_ctrl_tb_top.sv
module rst_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, gen_req_in = 0;
    logic        sample_stb = 0, ien_set = 0, ien_clr = 0, mask_wr = 0;
    logic [2:0]  mask_data = 3'b000;
    logic        accept, gen_ack, ien;
    logic [2:0]  src_code, mask_q;
    logic [15:0] vector;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct packed {
        logic        acc;
        logic [2:0]  src;
        logic [15:0] vec;
        logic        gack;
    } exp_t;

    exp_t exp_q[$];
    logic       m_ien  = 1'b0;
    logic [2:0] m_mask = 3'b000;

    always #2.5 clk = ~clk;

    rst_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .trap_in(trap_in), .rst75_in(rst75_in),
        .rst65_in(rst65_in), .rst55_in(rst55_in), .gen_req_in(gen_req_in),
        .sample_stb(sample_stb), .ien_set(ien_set), .ien_clr(ien_clr),
        .mask_wr(mask_wr), .mask_data(mask_data), .accept(accept),
        .src_code(src_code), .vector(vector), .gen_ack(gen_ack),
        .ien(ien), .mask_q(mask_q)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // reference model: R3 priority, R4 trap, R5 masks, R6 enable, R8 codes, R9 general
    function automatic exp_t model(logic t, logic a, logic b, logic c, logic g);
        exp_t e;
        e = '{acc: 1'b0, src: 3'd0, vec: 16'h0, gack: 1'b0};
        if (t)                         e = '{acc: 1'b1, src: 3'd1, vec: 16'h0024, gack: 1'b0};
        else if (a && m_ien && !m_mask[2]) e = '{acc: 1'b1, src: 3'd2, vec: 16'h003C, gack: 1'b0};
        else if (b && m_ien && !m_mask[1]) e = '{acc: 1'b1, src: 3'd3, vec: 16'h0034, gack: 1'b0};
        else if (c && m_ien && !m_mask[0]) e = '{acc: 1'b1, src: 3'd4, vec: 16'h002C, gack: 1'b0};
        else if (g && m_ien)           e = '{acc: 1'b1, src: 3'd5, vec: 16'h0000, gack: 1'b1};
        return e;
    endfunction

    // driver: one strobe with the given input levels
    task automatic fire(input logic t, input logic a, input logic b, input logic c, input logic g);
        exp_t e;
        @(negedge clk);
        {trap_in, rst75_in, rst65_in, rst55_in, gen_req_in} = {t, a, b, c, g};
        sample_stb = 1'b1;
        e = model(t, a, b, c, g);
        if (e.acc && e.src != 3'd1) m_ien = 1'b0;   // R7
        exp_q.push_back(e);
        @(negedge clk);
        sample_stb = 1'b0;
        {trap_in, rst75_in, rst65_in, rst55_in, gen_req_in} = '0;
        @(negedge clk);
    endtask

    task automatic set_ien(input logic s, input logic c);
        @(negedge clk);
        ien_set = s; ien_clr = c;
        @(negedge clk);
        ien_set = 0; ien_clr = 0;
        if (c) m_ien = 1'b0; else if (s) m_ien = 1'b1;
        chk(ien == m_ien, "R6 enable flag", ien, m_ien);
    endtask

    task automatic set_mask(input logic [2:0] m);
        @(negedge clk);
        mask_wr = 1'b1; mask_data = m;
        @(negedge clk);
        mask_wr = 1'b0;
        m_mask = m;
        chk(mask_q == m, "R5 mask load", mask_q, m);
    endtask

    // monitor: pops expected grant after each strobe
    initial begin
        forever begin
            @(posedge clk);
            if (sample_stb && !rst) begin
                exp_t e;
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 scoreboard empty", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    chk(accept == e.acc, "R2/R3 accept", accept, e.acc);
                    chk(src_code == e.src, "R3/R8 src_code", src_code, e.src);
                    chk(vector == e.vec, "R8 vector", vector, e.vec);
                    chk(gen_ack == e.gack, "R9 gen_ack", gen_ack, e.gack);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(ien == 1'b0, "R1 ien", ien, 0);
        chk(mask_q == 3'b000, "R1 mask", mask_q, 0);
        chk(accept == 1'b0 && src_code == 3'd0 && vector == 16'h0 && gen_ack == 1'b0,
            "R1 outputs", {accept, src_code}, 0);

        // R4 trap with flag off, R11 flag untouched
        fire(1, 0, 0, 0, 0);
        chk(ien == 1'b0, "R11 ien after trap", ien, 0);
        // R6 restart ignored while disabled
        fire(0, 1, 1, 1, 1);
        set_ien(1, 0);
        fire(0, 0, 1, 0, 0);
        chk(ien == 1'b0, "R7 ien cleared", ien, 0);
        // R3 all pending: trap wins, R11 flag stays set
        set_ien(1, 0);
        fire(1, 1, 1, 1, 1);
        chk(ien == 1'b1, "R11 ien kept", ien, 1);
        fire(0, 1, 1, 1, 1);
        set_ien(1, 0);
        fire(0, 0, 0, 1, 1);
        set_ien(1, 0);
        fire(0, 0, 0, 0, 1);  // R9 general request
        // R5 masks
        set_mask(3'b100);
        set_ien(1, 0);
        fire(0, 1, 0, 1, 0);
        set_mask(3'b111);
        set_ien(1, 0);
        fire(0, 1, 1, 1, 1);
        set_mask(3'b000);
        // R2 no strobe: no acceptance while lines are held
        set_ien(1, 0);
        @(negedge clk);
        rst75_in = 1'b1; gen_req_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(accept == 1'b0, "R2 no strobe", accept, 0);
        end
        rst75_in = 1'b0; gen_req_in = 1'b0;
        chk(ien == 1'b1, "R2 ien untouched", ien, 1);
        // R10 loser taken later only if still held
        fire(0, 1, 0, 1, 0);
        set_ien(1, 0);
        fire(0, 0, 0, 1, 0);
        set_ien(1, 0);
        fire(0, 0, 0, 0, 0);  // R10 nothing held: nothing accepted
        // R6 clear wins over set
        set_ien(1, 1);
        fire(0, 0, 0, 1, 0);
        // R7 acceptance wins over ien_set in the strobe cycle
        set_ien(1, 0);
        @(negedge clk);
        rst65_in = 1'b1; sample_stb = 1'b1; ien_set = 1'b1;
        exp_q.push_back(model(0, 0, 1, 0, 0));
        m_ien = 1'b0;
        @(negedge clk);
        rst65_in = 1'b0; sample_stb = 1'b0; ien_set = 1'b0;
        chk(ien == 1'b0, "R7 accept beats set", ien, 0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule